// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt lines and presents one request to the processor. Each request is a priority level and a vector number. Every line has a pending bit that follows the line. Software can also force any source pending, mask it, and give it an 8-bit priority level. A level of zero turns the source off.

Every cycle a comparison tree finds the eligible source with the highest level. On equal levels the higher-numbered source wins. The winner's level and its vector (source number plus 64) go to registered outputs. When nothing is eligible, the outputs show level 0 and vector 24.

Software reaches all state through a byte-addressed register window of 256 bytes, using 32-bit data. Reads are combinational. A write takes effect at the clock edge where `bus_wr` is high. The key offsets are listed below:

| Offset | Register |
|--------|----------|
| 0x00 / 0x04 | Pending, high and low words (read-only) |
| 0x08 / 0x0C | Mask, high and low words |
| 0x10 / 0x14 | Force, high and low words |
| 0x1C | Set one mask bit |
| 0x1D | Clear one mask bit |
| 0x40 to 0x7F | Per-source level registers |
| 0xE0 | Software acknowledge |

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_level` is 0 and `irq_vector` is 24. Reading 0xE0 returns 24. Every level register reads 0, the force words read 0, and both mask words read 0xFFFFFFFF.
- R2: Source n's pending bit takes the value of `irq_in[n]` at each clock edge. Offset 0x00 reads pending bits 63..32 and offset 0x04 reads bits 31..0. Writes to 0x00 and 0x04 change nothing.
- R3: Source n is eligible when (pending[n] or force[n]) is 1, its level is nonzero, and mask[n] is 0.
- R4: Writing a nonzero level enables a source. Writing a zero level disables it, even while its line is high and it is unmasked.
- R5: Among eligible sources, the highest level wins. On equal levels, the higher source number wins.
- R6: With a winner, `irq_level` equals the winner's level and `irq_vector` equals the winner's number plus 64. Outputs reflect state on the edge after the state changes, so they lag a bus write or an input change by two edges.
- R7: With no eligible source, `irq_level` is 0 and `irq_vector` is 24.
- R8: Offset 0x08 holds mask bits 63..32 and 0x0C holds mask bits 31..0. Offset 0x10 holds force bits 63..32 and 0x14 holds force bits 31..0. Each is a full 32-bit word and reads back what was written.
- R9: A write to 0x1C sets the mask bit indexed by `bus_wdata[5:0]`. A write to 0x1D clears that bit. Higher data bits are ignored.
- R10: A read of 0xE0 returns the current `irq_vector`, zero-extended. Reads of 0xE1 through 0xE7 return 0.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register and no output.
- R12: The level register of source n sits at offset 0x40+n. A write stores `bus_wdata[7:0]`, and a read returns that byte zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 64 | Level-sensitive interrupt lines, bit n is source n |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_level | output | 8 | Priority level of the current winner, 0 when idle |
| irq_vector | output | 8 | Vector of the current winner, 24 when idle |

## Verification
The assertions check the following on every cycle:
- The idle pair (level 0 with vector 24) always appears together.
- A nonzero level always comes with a vector in 64..127.
- The winner named by the outputs was eligible in the previous cycle and carried exactly the level shown.
- Each pending bit tracks its line.
- The set-mask and clear-mask writes act on the indexed bit.
- The acknowledge offset mirrors the vector.

Only the bench's scenarios show that the winner is the best candidate. This covers the tie going to the higher number, a higher level beating it, and a zero-level write removing a source. The scenarios also show that forced sources compete like pending ones, that word and bit masking agree, and that ignored or unmapped writes leave everything unchanged.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, register offsets and vector constants for the
// interrupt controller. Assumes 64 sources split into two 32-bit words.
package irqc_pkg;
    localparam int SRC_N   = 64;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int LVL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int VEC_W   = 8;
    localparam int HALF_N  = SRC_N / 2;

    localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;
    localparam logic [VEC_W-1:0] VEC_IDLE = 8'd24;

    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FRC_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FRC_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_MSET    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_MCLR    = 8'h1D;
    localparam logic [ADDR_W-1:0] OFS_SWACK   = 8'hE0;
    localparam logic [1:0]        LVL_PAGE    = 2'b01;
endpackage

// File: rtl/irqc_regs.sv
// Register file: pending, mask, force and per-source level registers plus
// the read multiplexer. Assumes single-cycle writes and combinational reads.
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_N-1:0]        irq_in,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [VEC_W-1:0]        vec_cur,
    output logic [DATA_W-1:0]       rdata,
    output logic [SRC_N-1:0]        pend_q,
    output logic [SRC_N-1:0]        mask_q,
    output logic [SRC_N-1:0]        force_q,
    output logic [SRC_N*LVL_W-1:0]  lvl_flat
);
    logic [LVL_W-1:0] lvl_q [SRC_N];
    logic             lvl_hit;

    assign lvl_hit = (addr[ADDR_W-1:ADDR_W-2] == LVL_PAGE);

    // Pending bits sample the interrupt lines every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_in;
    end

    // Mask register: word writes plus single-bit set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en) begin
            case (addr)
                OFS_MASK_HI: mask_q[SRC_N-1:HALF_N] <= wdata;
                OFS_MASK_LO: mask_q[HALF_N-1:0]     <= wdata;
                OFS_MSET:    mask_q[wdata[IDX_W-1:0]] <= 1'b1;
                OFS_MCLR:    mask_q[wdata[IDX_W-1:0]] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Force register: written as two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_FRC_HI) force_q[SRC_N-1:HALF_N] <= wdata;
            if (addr == OFS_FRC_LO) force_q[HALF_N-1:0]     <= wdata;
        end
    end

    // Level registers: one byte per source in the level page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SRC_N; i++) lvl_q[i] <= '0;
        end else if (wr_en && lvl_hit) begin
            lvl_q[addr[IDX_W-1:0]] <= wdata[LVL_W-1:0];
        end
    end

    // Flatten the level array for the arbiter.
    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_flat
            assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q[g];
        end
    endgenerate

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        if (lvl_hit) begin
            rdata = DATA_W'(lvl_q[addr[IDX_W-1:0]]);
        end else begin
            case (addr)
                OFS_PEND_HI: rdata = pend_q[SRC_N-1:HALF_N];
                OFS_PEND_LO: rdata = pend_q[HALF_N-1:0];
                OFS_MASK_HI: rdata = mask_q[SRC_N-1:HALF_N];
                OFS_MASK_LO: rdata = mask_q[HALF_N-1:0];
                OFS_FRC_HI:  rdata = force_q[SRC_N-1:HALF_N];
                OFS_FRC_LO:  rdata = force_q[HALF_N-1:0];
                OFS_SWACK:   rdata = DATA_W'(vec_cur);
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Priority arbiter: a balanced binary compare tree over N sources.
// Assumes N is a power of two. On equal levels the right (higher-numbered)
// child wins, giving the tie to the higher source.
module irqc_arbiter #(
    parameter int N  = 64,
    parameter int LW = 8,
    localparam int IW    = $clog2(N),
    localparam int NODES = 2*N - 1
) (
    input  logic [N-1:0]    active,
    input  logic [N*LW-1:0] lvl_flat,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [LW-1:0]   win_lvl
);
    logic          n_vld [NODES];
    logic [LW-1:0] n_lvl [NODES];
    logic [IW-1:0] n_idx [NODES];

    genvar i, k;
    generate
        // Leaves: one per source, heap positions N-1 .. 2N-2.
        for (i = 0; i < N; i++) begin : g_leaf
            assign n_vld[N-1+i] = active[i];
            assign n_lvl[N-1+i] = lvl_flat[i*LW +: LW];
            assign n_idx[N-1+i] = IW'(i);
        end
        // Inner nodes: keep the better of the two children.
        for (k = 0; k < N-1; k++) begin : g_node
            logic pick_r;
            assign pick_r = n_vld[2*k+2] &&
                            (!n_vld[2*k+1] || (n_lvl[2*k+2] >= n_lvl[2*k+1]));
            assign n_vld[k] = n_vld[2*k+1] || n_vld[2*k+2];
            assign n_lvl[k] = pick_r ? n_lvl[2*k+2] : n_lvl[2*k+1];
            assign n_idx[k] = pick_r ? n_idx[2*k+2] : n_idx[2*k+1];
        end
    endgenerate

    assign found   = n_vld[0];
    assign win_idx = n_idx[0];
    assign win_lvl = n_lvl[0];
endmodule

// File: rtl/irqc_top.sv
// Interrupt controller top: forms the eligibility vector, runs the
// arbiter and registers the level and vector toward the processor.
// Assumes a source is enabled exactly when its level register is nonzero.
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       irq_in,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        irq_level,
    output logic [7:0]        irq_vector
);
    logic [SRC_N-1:0]       pend_q, mask_q, force_q, enab, active;
    logic [SRC_N*LVL_W-1:0] lvl_flat;
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    logic [LVL_W-1:0]       win_lvl;

    irqc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .vec_cur  (irq_vector),
        .rdata    (bus_rdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .force_q  (force_q),
        .lvl_flat (lvl_flat)
    );

    // Enable bit per source: set by any nonzero level.
    genvar g;
    generate
        for (g = 0; g < SRC_N; g++) begin : g_en
            assign enab[g] = |lvl_flat[g*LVL_W +: LVL_W];
        end
    endgenerate

    // Eligibility: pending or forced, enabled, and unmasked.
    assign active = (pend_q | force_q) & enab & ~mask_q;

    irqc_arbiter #(.N(SRC_N), .LW(LVL_W)) u_arb (
        .active   (active),
        .lvl_flat (lvl_flat),
        .found    (found),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    // Output registers: the winner's level and vector, or the idle pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= VEC_IDLE;
        end else if (found) begin
            irq_level  <= win_lvl;
            irq_vector <= VEC_BASE + VEC_W'(win_idx);
        end else begin
            irq_level  <= '0;
            irq_vector <= VEC_IDLE;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Checker for irqc_top: keeps one-cycle copies of the register state and
// checks the output relations. Attached by the bind at the end of the file.
module irqc_checker
    import irqc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [SRC_N-1:0]       irq_in,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [LVL_W-1:0]       irq_level,
    input logic [VEC_W-1:0]       irq_vector,
    input logic [SRC_N-1:0]       pend_q,
    input logic [SRC_N-1:0]       mask_q,
    input logic [SRC_N-1:0]       force_q,
    input logic [SRC_N*LVL_W-1:0] lvl_flat
);
    logic [SRC_N-1:0]       pend_d, mask_d, force_d;
    logic [SRC_N*LVL_W-1:0] lvl_d;
    logic [IDX_W-1:0]       win_c;

    // Delayed copies of the state the outputs were computed from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_d  <= '0;
            mask_d  <= '1;
            force_d <= '0;
            lvl_d   <= '0;
        end else begin
            pend_d  <= pend_q;
            mask_d  <= mask_q;
            force_d <= force_q;
            lvl_d   <= lvl_flat;
        end
    end

    assign win_c = IDX_W'(irq_vector - VEC_BASE);

    a_r7_idle_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == '0) |-> (irq_vector == VEC_IDLE));

    a_r6_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_vector >= 8'd64 && irq_vector <= 8'd127));

    a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (!mask_d[win_c] && (pend_d[win_c] || force_d[win_c])));

    a_r5_winner_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_level == lvl_d[win_c*LVL_W +: LVL_W]));

    a_r2_pending_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q == $past(irq_in)));

    a_r9_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MSET) |=> mask_q[$past(bus_wdata[IDX_W-1:0])]);

    a_r9_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MCLR) |=> !mask_q[$past(bus_wdata[IDX_W-1:0])]);

    a_r10_swack_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_SWACK) |-> (bus_rdata == DATA_W'(irq_vector)));
endmodule

bind irqc_top irqc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_level  (irq_level),
    .irq_vector (irq_vector),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .force_q    (force_q),
    .lvl_flat   (lvl_flat)
);

// File: tb/irqc_top_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module irqc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u_irqc_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_level  (irq_level),
        .irq_vector (irq_vector)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Write: held over one rising edge, released on the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // One more edge so the output registers pick up the new state.
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_out(input string req, input logic [7:0] lvl, input logic [7:0] vec);
        check(req, {24'b0, irq_level}, {24'b0, lvl});
        check(req, {24'b0, irq_vector}, {24'b0, vec});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk_out("R1 reset outputs", 8'd0, 8'd24);
        rd(8'hE0, d); check("R1 swack after reset", d, 32'd24);
        rd(8'h08, d); check("R1 mask hi", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R1 mask lo", d, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R1 force hi", d, 32'h0);
        rd(8'h45, d); check("R1 level reg", d, 32'h0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        @(negedge clk); irq_in[3] = 1'b1;
        rd(8'h04, d); check("R2 pending lo", d, 32'h8);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R2 pending write ignored", d, 32'h8);
        wr(8'h0C, 32'hFFFF_FFF7);
        settle();
        chk_out("R4 zero level keeps source off", 8'd0, 8'd24);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        wr(8'h43, 32'd5);
        settle();
        chk_out("R6 single winner", 8'd5, 8'd67);
        rd(8'hE0, d); check("R10 swack vector", d, 32'd67);
        @(negedge clk); irq_in[3] = 1'b0;
        settle();
        chk_out("R2 line low drops request", 8'd0, 8'd24);
        @(negedge clk); irq_in[3] = 1'b1;
        settle();
        chk_out("R2 line high again", 8'd5, 8'd67);
    endtask

    task automatic t_mask_bits();
        logic [31:0] d;
        wr(8'h1C, 32'd3);
        settle();
        chk_out("R9 set-mask blocks source", 8'd0, 8'd24);
        wr(8'h1D, 32'hFFFF_FFC3);
        rd(8'h0C, d); check("R9 clear-mask uses low bits", d, 32'hFFFF_FFF7);
        settle();
        chk_out("R3 unmasked source back", 8'd5, 8'd67);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        @(negedge clk); irq_in[40] = 1'b1;
        wr(8'h68, 32'd5);
        wr(8'h08, 32'hFFFF_FEFF);
        rd(8'h08, d); check("R8 mask hi word", d, 32'hFFFF_FEFF);
        settle();
        chk_out("R5 tie goes to higher source", 8'd5, 8'd104);
        wr(8'h43, 32'd6);
        settle();
        chk_out("R5 higher level wins", 8'd6, 8'd67);
        rd(8'h43, d); check("R12 level readback", d, 32'd6);
        wr(8'h43, 32'h0000_0100);
        rd(8'h43, d); check("R12 only low byte stored", d, 32'd0);
        settle();
        chk_out("R4 zero level disables", 8'd5, 8'd104);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(8'h7F, 32'd2);
        wr(8'h1D, 32'd63);
        wr(8'h10, 32'h8000_0000);
        rd(8'h10, d); check("R8 force hi word", d, 32'h8000_0000);
        settle();
        chk_out("R5 level 5 beats forced level 2", 8'd5, 8'd104);
        @(negedge clk); irq_in = '0;
        settle();
        chk_out("R3 forced source alone", 8'd2, 8'd127);
        wr(8'h10, 32'h0);
        settle();
        chk_out("R7 idle after force clear", 8'd0, 8'd24);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'hE3, d); check("R10 level ack reads zero", d, 32'h0);
        rd(8'h18, d); check("R11 unmapped read", d, 32'h0);
        rd(8'h80, d); check("R11 unmapped read high", d, 32'h0);
        wr(8'h18, 32'h0000_0000);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h1E, 32'd40);
        rd(8'h08, d); check("R11 mask hi unchanged", d, 32'h7FFF_FEFF);
        rd(8'h14, d); check("R11 force lo unchanged", d, 32'h0);
        @(negedge clk); irq_in[40] = 1'b1;
        settle();
        chk_out("R11 outputs after stray writes", 8'd5, 8'd104);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending();
        t_basic();
        t_mask_bits();
        t_priority();
        t_force();
        t_unmapped();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule